// File: doc/BRIEF.md
# Multiphase Stepped-Sine Generator

The block turns a free-running twisted-ring shift register into one or more stepped sine waves. A chain of single-bit stages feeds the inverse of its last stage back into its first. After reset it steps through a 2·STAGES-long pattern: the stages fill with ones from the low end, then empty again. Every stage has a fixed integer weight. The weights of the stages that hold a one are added together, and the sum is shifted to a signed sample. The weights are chosen so that the samples trace a cosine-shaped wave with a period of 24 clocks at the default size.

Extra phases come from non-recirculating copies of the pattern. Each copy is a second chain of the same length. It is fed from a selectable tap of the chain before it, and its bits drop off its far end. Each copy drives its own weighted summer. The tap picks how many clocks the copy lags the previous phase, in 15° steps from 15° to 180°. Lags of six steps give quadrature outputs. Lags of eight steps on two copies give three-phase outputs.

In this document, "cycle t" counts the rising clock edges since `rst_i` was released, and cycle 0 is the state directly after release. The default size is STAGES = 12, NUM_PH = 3 and AMP = 1000. T(n) stands for round(AMP·(1 − cos(15°·n))).

Top module: `jsine_gen`

## Requirements
- R1: While `rst_i` is high, and at cycle 0 after its release, every phase outputs −AMP.
- R2: Phase 0 at cycle t, with n = t mod 24, equals T(n) − AMP for n from 0 to 12, and AMP − T(n − 12) for n from 13 to 23.
- R3: Phase 0 repeats with a period of exactly 24 cycles: its sample at cycle t equals its sample at cycle t − 24.
- R4: Every phase stays within −AMP to +AMP. Phase 0 is exactly +AMP at step 12 and exactly −AMP at step 0.
- R5: The lag code of phase p (p ≥ 1) sits in bits [4p−1 : 4p−4] of `tap_sel_i`. Code c from 0 to 11 makes phase p lag phase p−1 by c+1 clocks, which is (c+1)·15°. Codes 12 to 15 all give a lag of 12 clocks (180°).
- R6: With a lag of d clocks in force, phase p at cycle t equals phase p−1 at cycle t − d, or −AMP when t < d. Code 5 on phase 1 gives quadrature. Code 7 on phases 1 and 2 gives lags of 120° and 240° against phase 0.
- R7: A lag code is accepted only at a clock edge where phase 0 is at step 0 (its ring is all zeros). A change of `tap_sel_i` at any other edge has no effect until the next such edge.
- R8: After a new lag is accepted at edge k, the R6 relation for that phase holds exactly for every cycle from k + 11 onward. Phase 0 is never disturbed by a lag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock for all stages |
| rst_i | input | 1 | Synchronous reset, active high, clears every stage |
| tap_sel_i | input | 4·(NUM_PH−1) | Lag codes, one 4-bit field per extra phase |
| sample_o | output | 12·NUM_PH | Signed samples; phase p in bits [12p+11 : 12p] |

## Verification
Fixed lag codes after a fresh reset test the pure pattern. Quadrature (code 5), three-phase (code 7 twice) and the two extreme codes 0 and 14 each pin phase outputs to the cosine table at a known absolute offset. These runs separate a wrong tap index or wrong saturation from a wrong weight. A long random run changes the codes at arbitrary cycles, both on and off the step-0 boundary. It checks each phase against the observed history of the phase before it. This catches a code that is latched mid-period, which would break R7, and a tap that is used before the chain has flushed, which would break R8. The cosine table and the 24-cycle repeat of phase 0 are checked on every sample. A second reset in the middle of the run confirms that all state is cleared.

// File: rtl/jsine_pkg.sv
package jsine_pkg;

    // Level reached after n ones have entered the ring:
    // round(amp * (1 - cos(pi * n / len)))
    function automatic int unsigned fill_level(int unsigned n, int unsigned amp, int unsigned len);
        real ang;
        real lvl;
        ang = 3.14159265358979 * real'(n) / real'(len);
        lvl = real'(amp) * (1.0 - $cos(ang));
        return $rtoi(lvl + 0.5);
    endfunction

    // Weight of stage i: the step between consecutive fill levels
    function automatic int unsigned stage_weight(int unsigned i, int unsigned amp, int unsigned len);
        return fill_level(i + 1, amp, len) - fill_level(i, amp, len);
    endfunction

endpackage

// File: rtl/jsine_ring.sv
module jsine_ring #(
    parameter int STAGES = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [STAGES-1:0] stages_o,
    output logic              wrap_o
);

    localparam logic [STAGES-1:0] FIRST_ONE = {{(STAGES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STAGES-1:0] ring;
    } ring_t;

    ring_t st_d;
    ring_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ring = {st_q.ring[STAGES-2:0], ~st_q.ring[STAGES-1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages_o = st_q.ring;
    assign wrap_o   = (st_q.ring == '0);

    // R3
    johnson_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(st_q.ring[STAGES-1:1] ^ st_q.ring[STAGES-2:0]) <= 1);

    // R3
    wrap_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (st_q.ring == FIRST_ONE));

    // R3
    full_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (&st_q.ring) |=> (st_q.ring == ~FIRST_ONE));

endmodule

// File: rtl/jsine_delay.sv
module jsine_delay #(
    parameter int STAGES = 12,
    parameter int DLY_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wrap_i,
    input  logic [DLY_W-1:0]  code_i,
    input  logic [STAGES-1:0] up_i,
    output logic [STAGES-1:0] bits_o
);

    localparam logic [DLY_W-1:0] TOP_CODE = DLY_W'(STAGES - 1);

    typedef struct packed {
        logic [DLY_W-1:0]  code;
        logic [STAGES-1:0] bits;
    } dly_t;

    dly_t             st_d;
    dly_t             st_q;
    logic [DLY_W-1:0] code_use;
    logic [DLY_W-1:0] tap_idx;

    always_comb begin
        st_d      = st_q;
        code_use  = wrap_i ? code_i : st_q.code;
        tap_idx   = (code_use > TOP_CODE) ? TOP_CODE : code_use;
        st_d.code = code_use;
        st_d.bits = {st_q.bits[STAGES-2:0], up_i[tap_idx]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.code <= TOP_CODE;
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;

    // R7
    code_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(st_q.code));

    // R7
    code_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_i |=> (st_q.code == $past(code_i)));

endmodule

// File: rtl/jsine_summer.sv
module jsine_summer #(
    parameter int STAGES = 12,
    parameter int AMP    = 1000,
    parameter int SUM_W  = 11,
    parameter int OUT_W  = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [STAGES-1:0]       bits_i,
    output logic signed [OUT_W-1:0] sample_o
);

    localparam logic signed [OUT_W-1:0] PEAK = OUT_W'(AMP);

    logic [SUM_W-1:0] term [STAGES];
    logic [SUM_W-1:0] acc;

    for (genvar i = 0; i < STAGES; i++) begin : g_w
        localparam int unsigned WT = jsine_pkg::stage_weight(i, AMP, STAGES);
        assign term[i] = bits_i[i] ? SUM_W'(WT) : '0;
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < STAGES; i++) begin
            acc = acc + term[i];
        end
        sample_o = $signed({1'b0, acc}) - PEAK;
    end

    // R4
    range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sample_o >= -PEAK) && (sample_o <= PEAK));

    // R4
    peak_hi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (&bits_i) |-> (sample_o == PEAK));

    // R1
    peak_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bits_i == '0) |-> (sample_o == -PEAK));

endmodule

// File: rtl/jsine_gen.sv
module jsine_gen #(
    parameter  int STAGES = 12,
    parameter  int NUM_PH = 3,
    parameter  int AMP    = 1000,
    localparam int DLY_W  = $clog2(STAGES),
    localparam int SUM_W  = $clog2(2 * AMP + 1),
    localparam int OUT_W  = SUM_W + 1,
    localparam int SEL_W  = DLY_W * (NUM_PH - 1)
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [SEL_W-1:0]          tap_sel_i,
    output logic [OUT_W*NUM_PH-1:0]   sample_o
);

    logic [STAGES-1:0] ph_bits [NUM_PH];
    logic              wrap;

    jsine_ring #(.STAGES(STAGES)) u_ring (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .stages_o (ph_bits[0]),
        .wrap_o   (wrap)
    );

    for (genvar p = 1; p < NUM_PH; p++) begin : g_lag
        jsine_delay #(.STAGES(STAGES), .DLY_W(DLY_W)) u_dly (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .wrap_i (wrap),
            .code_i (tap_sel_i[(p-1)*DLY_W +: DLY_W]),
            .up_i   (ph_bits[p-1]),
            .bits_o (ph_bits[p])
        );
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_sum
        jsine_summer #(
            .STAGES (STAGES),
            .AMP    (AMP),
            .SUM_W  (SUM_W),
            .OUT_W  (OUT_W)
        ) u_sum (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .bits_i   (ph_bits[p]),
            .sample_o (sample_o[p*OUT_W +: OUT_W])
        );
    end

    // R2
    wrap_min_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap |-> ($signed(sample_o[OUT_W-1:0]) == -$signed(OUT_W'(AMP))));

endmodule

// File: tb/sim_jsine_gen.sv
`timescale 1ns/1ps
module sim_jsine_gen;

    localparam int NUM_PH = 3;
    localparam int AMP    = 1000;
    localparam int DLY_W  = 4;
    localparam int OUT_W  = 12;
    localparam int SEL_W  = DLY_W * (NUM_PH - 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [SEL_W-1:0]        sel = '0;
    logic [OUT_W*NUM_PH-1:0] smp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit rnd_mode = 1'b0;
    bit static_mode = 1'b0;
    string static_tag = "R6";
    int t = 0;
    int eff_d    [NUM_PH];
    int chg_edge [NUM_PH];
    bit pend     [NUM_PH];
    int hist     [NUM_PH][32];

    jsine_gen u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .tap_sel_i (sel),
        .sample_o  (smp)
    );

    always #4 clk = ~clk;

    function automatic int tgt(int n);
        return $rtoi(AMP * (1.0 - $cos(3.14159265358979 * n / 12.0)) + 0.5);
    endfunction

    function automatic int ref_s(int n);
        int m;
        m = n % 24;
        if (m <= 12) return tgt(m) - AMP;
        return AMP - tgt(m - 12);
    endfunction

    function automatic int code2d(int c);
        return (c > 11) ? 12 : c + 1;
    endfunction

    function automatic int code_of(int p);
        return int'(sel[(p-1)*DLY_W +: DLY_W]);
    endfunction

    function automatic int outp(int p);
        return int'($signed(smp[p*OUT_W +: OUT_W]));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at t=%0d: actual %0d expected %0d", req, t, act, exp);
        end
    endtask

    task automatic sample_check();
        int exp;
        int cum;
        string tag;
        for (int p = 0; p < NUM_PH; p++) hist[p][t % 32] = outp(p);
        chk("R2", outp(0), ref_s(t));
        if (t >= 24) chk("R3", outp(0), hist[0][(t - 24) % 32]);
        if (t % 24 == 12) chk("R4 peak", outp(0), AMP);
        if (t % 24 == 0)  chk("R4 floor", outp(0), -AMP);
        if (t == 0) begin
            for (int p = 1; p < NUM_PH; p++) chk("R1 release", outp(p), -AMP);
        end
        for (int p = 1; p < NUM_PH; p++) begin
            if (outp(p) < -AMP || outp(p) > AMP) chk("R4 range", outp(p), AMP);
            if (t - chg_edge[p] >= 11) begin
                exp = (t < eff_d[p]) ? -AMP : hist[p-1][(t - eff_d[p]) % 32];
                if (pend[p])                    tag = "R7";
                else if (t - chg_edge[p] < 24)  tag = "R8";
                else                            tag = "R6";
                chk(tag, outp(p), exp);
            end
        end
        if (static_mode) begin
            cum = 0;
            for (int p = 1; p < NUM_PH; p++) begin
                cum += eff_d[p];
                exp = (t < cum) ? -AMP : ref_s(t - cum);
                chk(static_tag, outp(p), exp);
            end
        end
    endtask

    task automatic drive();
        int nd;
        if (rnd_mode && ($urandom % 6 == 0)) sel = SEL_W'($urandom);
        for (int p = 1; p < NUM_PH; p++) begin
            nd = code2d(code_of(p));
            if (t % 24 == 0) begin
                if (t != 0 && nd != eff_d[p]) chg_edge[p] = t + 1;
                eff_d[p] = nd;
                pend[p]  = 1'b0;
            end else if (nd != eff_d[p]) begin
                pend[p] = 1'b1;
            end else begin
                pend[p] = 1'b0;
            end
        end
    endtask

    task automatic do_reset(int c1, int c2);
        @(negedge clk);
        rst = 1'b1;
        sel = {DLY_W'(c2), DLY_W'(c1)};
        repeat (3) begin
            @(negedge clk);
            for (int p = 0; p < NUM_PH; p++) chk("R1 hold", outp(p), -AMP);
        end
        rst = 1'b0;
        t = 0;
        for (int p = 0; p < NUM_PH; p++) begin
            chg_edge[p] = -100;
            pend[p]     = 1'b0;
            eff_d[p]    = (p == 0) ? 0 : code2d(code_of(p));
        end
        sample_check();
        drive();
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            t++;
            sample_check();
            drive();
        end
    endtask

    initial begin
        void'($urandom(32'd20240613));
        // quadrature: phase 1 lags 90 degrees
        static_mode = 1'b1; static_tag = "R6";
        do_reset(5, 5);
        run(60);
        // three-phase: 120 and 240 degrees
        do_reset(7, 7);
        run(60);
        // out-of-range codes saturate at 180 degrees
        static_tag = "R5";
        do_reset(14, 12);
        run(60);
        // smallest code gives one clock of lag
        do_reset(0, 11);
        run(50);
        // random codes, changed on and off the period boundary
        static_mode = 1'b0;
        rnd_mode = 1'b1;
        do_reset(3, 9);
        run(1500);
        // reset in the middle of activity
        do_reset(int'($urandom % 16), int'($urandom % 16));
        run(900);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R1..R8 not completed): actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule